// File: doc/BRIEF.md
# Four-Bank Tightly Coupled Data Memory Arbiter

This block places a data memory next to a processor. The memory is built from four banks, each one 32-bit word wide, and consecutive words rotate through the banks. Byte address bits 3:2 pick the bank. The memory serves two requesters. The processor port moves either one word or an aligned 64-bit doubleword per access. A doubleword occupies a pair of adjacent banks. The DMA port stands in for a system bus subordinate and moves one word per access. Because the banks are independent, the two ports can be served in the same cycle whenever they touch different banks, so DMA traffic can fill or drain the memory while software runs.

Each bank is arbitrated on its own. The processor always has priority over the DMA for a bank that both want. A DMA request is refused for a bank the processor is asking for, even when the processor is itself stalled, and it proceeds once the processor has moved to other banks. Every bank inserts a fixed number of wait states (`WAIT_STATES`). Each bank runs a two-state controller:
- `BK_IDLE` → `BK_STALL` when an access is accepted and wait states are configured.
- `BK_STALL` → `BK_IDLE` when the wait counter reaches its last cycle.
- With zero wait states the bank stays in `BK_IDLE` and can take an access every cycle.

Read data is registered and returned to the requester that issued the read.

Top module: `tcm_bank_arbiter`

## Requirements
- R1: After reset, neither `cpu_rvalid` nor `dma_rvalid` is asserted. A ready output is never high while its request input is low.
- R2: Both ports address one shared memory. A word written at a byte address through one port is read back at that same address through the other port. The bank used is `addr[3:2]`.
- R3: `cpu_wide=1` selects a 64-bit access. Its address must have bits 2:0 at zero. It uses banks {0,1} when `addr[3]=0` and banks {2,3} when `addr[3]=1`. The lower 32 bits of `cpu_wdata`/`cpu_rdata`, together with `cpu_be[3:0]`, belong to the even bank (byte offset 0–3). The upper 32 bits, with `cpu_be[7:4]`, belong to the odd bank.
- R4: A processor access and a DMA access that need disjoint banks are both accepted in the same cycle.
- R5: When the processor requests a bank that the DMA also requests, `dma_ready` is low in that cycle, whether or not the processor is accepted.
- R6: A DMA request that was refused is accepted in the first cycle in which its bank is idle and is not requested by the processor.
- R7: Writes update only the bytes whose byte-enable bit is 1. Bit i of an enable covers byte i of the word or doubleword, little-endian.
- R8: Read data is returned exactly `1+WAIT_STATES` cycles after acceptance, on the port that issued the read. A 32-bit processor read returns its word in `cpu_rdata[31:0]` with the upper half zero.
- R9: After a bank accepts an access, it accepts nothing else for the next `WAIT_STATES` cycles. The ready output of any request needing that bank stays low during that time.
- R10: Write accesses produce no `cpu_rvalid` or `dma_rvalid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req | input | 1 | Processor access request |
| cpu_we | input | 1 | Processor write (1) or read (0) |
| cpu_wide | input | 1 | 64-bit access (1) or 32-bit access (0) |
| cpu_addr | input | AW | Processor byte address |
| cpu_wdata | input | 64 | Processor write data |
| cpu_be | input | 8 | Processor byte enables |
| cpu_ready | output | 1 | Processor access accepted this cycle |
| cpu_rvalid | output | 1 | Processor read data valid |
| cpu_rdata | output | 64 | Processor read data |
| dma_req | input | 1 | DMA access request, held until accepted |
| dma_we | input | 1 | DMA write (1) or read (0) |
| dma_addr | input | AW | DMA byte address |
| dma_wdata | input | 32 | DMA write data |
| dma_be | input | 4 | DMA byte enables |
| dma_ready | output | 1 | DMA access accepted this cycle |
| dma_rvalid | output | 1 | DMA read data valid |
| dma_rdata | output | 32 | DMA read data |

## Verification
Two things can happen in the same cycle: a processor grant and a DMA grant. They either share a bank, and the DMA must yield, or they use disjoint banks, and both must go through. Directed cases aim a word or doubleword processor access and a DMA access at the same bank, and then at disjoint banks. A randomized stretch keeps both ports busy, with doubleword accesses mixed in. The bench model tracks how long each bank stays busy. On every cycle it predicts both ready outputs, and it predicts the read data and the cycle in which that data appears on each port.

// File: rtl/tcm_arb_pkg.sv
package tcm_arb_pkg;

    localparam int NBANK  = 4;
    localparam int WORD_W = 32;
    localparam int BE_W   = WORD_W / 8;

    // Requester that owns a bank access.
    typedef enum logic {
        SRC_CPU = 1'b0,
        SRC_DMA = 1'b1
    } src_e;

    // Per-bank controller state.
    typedef enum logic {
        BK_IDLE  = 1'b0,
        BK_STALL = 1'b1
    } bank_state_e;

    // Travels with an access so the response is steered correctly.
    typedef struct packed {
        src_e src;
        logic rd;
        logic lane;
    } rsp_tag_t;

endpackage

// File: rtl/tcm_cpu_decode.sv
module tcm_cpu_decode
    import tcm_arb_pkg::*;
(
    input  logic             req,
    input  logic             wide,
    input  logic [3:2]       addr,
    output logic [NBANK-1:0] need,
    output logic [NBANK-1:0] lane
);

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        localparam logic [1:0] BID = 2'(b);
        // A wide access claims the whole pair picked by addr[3].
        assign need[b] = req & (wide ? (BID[1] == addr[3]) : (BID == addr[3:2]));
        // Odd bank of a pair carries the upper 32 bits of a wide access.
        assign lane[b] = wide & BID[0];
    end

endmodule

// File: rtl/tcm_bank.sv
module tcm_bank
    import tcm_arb_pkg::*;
#(
    parameter int IDXW        = 8,
    parameter int WAIT_STATES = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc,
    input  logic              we,
    input  logic [IDXW-1:0]   idx,
    input  logic [WORD_W-1:0] wdata,
    input  logic [BE_W-1:0]   be,
    input  rsp_tag_t          tag_in,
    output logic              idle,
    output logic              rsp_valid,
    output rsp_tag_t          rsp_tag,
    output logic [WORD_W-1:0] rsp_data
);

    localparam int   DEPTH     = 1 << IDXW;
    localparam int   CW        = (WAIT_STATES > 0) ? $clog2(WAIT_STATES + 1) : 1;
    localparam logic ZERO_WAIT = (WAIT_STATES == 0);

    bank_state_e       state_q, state_d;
    logic [CW-1:0]     cnt_q;
    logic              rsp_d;
    logic [WORD_W-1:0] mem [DEPTH];

    // State register, wait counter and response strobe.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= BK_IDLE;
            cnt_q     <= '0;
            rsp_valid <= 1'b0;
        end else begin
            state_q   <= state_d;
            rsp_valid <= rsp_d;
            if (acc) begin
                cnt_q <= CW'(WAIT_STATES);
            end else if (state_q == BK_STALL) begin
                cnt_q <= cnt_q - CW'(1);
            end
        end
    end

    // Next state and response timing.
    always_comb begin
        state_d = state_q;
        rsp_d   = 1'b0;
        unique case (state_q)
            BK_IDLE: begin
                if (acc) begin
                    if (ZERO_WAIT) begin
                        rsp_d = 1'b1;
                    end else begin
                        state_d = BK_STALL;
                    end
                end
            end
            BK_STALL: begin
                if (cnt_q == CW'(1)) begin
                    state_d = BK_IDLE;
                    rsp_d   = 1'b1;
                end
            end
            default: state_d = BK_IDLE;
        endcase
    end

    // Storage: byte-masked write, registered read captured at acceptance.
    always_ff @(posedge clk) begin
        if (acc) begin
            rsp_tag <= tag_in;
            if (we) begin
                for (int i = 0; i < BE_W; i++) begin
                    if (be[i]) begin
                        mem[idx][8*i +: 8] <= wdata[8*i +: 8];
                    end
                end
            end else begin
                rsp_data <= mem[idx];
            end
        end
    end

    assign idle = (state_q == BK_IDLE);

endmodule

// File: rtl/tcm_rd_steer.sv
module tcm_rd_steer
    import tcm_arb_pkg::*;
(
    input  logic     [NBANK-1:0]             rsp_valid,
    input  rsp_tag_t [NBANK-1:0]             rsp_tag,
    input  logic     [NBANK-1:0][WORD_W-1:0] rsp_data,
    output logic                             cpu_rvalid,
    output logic     [2*WORD_W-1:0]          cpu_rdata,
    output logic                             dma_rvalid,
    output logic     [WORD_W-1:0]            dma_rdata
);

    always_comb begin
        cpu_rvalid = 1'b0;
        cpu_rdata  = '0;
        dma_rvalid = 1'b0;
        dma_rdata  = '0;
        for (int b = 0; b < NBANK; b++) begin
            if (rsp_valid[b] && rsp_tag[b].rd) begin
                if (rsp_tag[b].src == SRC_CPU) begin
                    cpu_rvalid = 1'b1;
                    if (rsp_tag[b].lane) begin
                        cpu_rdata[2*WORD_W-1:WORD_W] = cpu_rdata[2*WORD_W-1:WORD_W] | rsp_data[b];
                    end else begin
                        cpu_rdata[WORD_W-1:0] = cpu_rdata[WORD_W-1:0] | rsp_data[b];
                    end
                end else begin
                    dma_rvalid = 1'b1;
                    dma_rdata  = dma_rdata | rsp_data[b];
                end
            end
        end
    end

endmodule

// File: rtl/tcm_bank_arbiter.sv
module tcm_bank_arbiter
    import tcm_arb_pkg::*;
#(
    parameter int AW          = 12,
    parameter int WAIT_STATES = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_req,
    input  logic          cpu_we,
    input  logic          cpu_wide,
    input  logic [AW-1:0] cpu_addr,
    input  logic [63:0]   cpu_wdata,
    input  logic [7:0]    cpu_be,
    output logic          cpu_ready,
    output logic          cpu_rvalid,
    output logic [63:0]   cpu_rdata,
    input  logic          dma_req,
    input  logic          dma_we,
    input  logic [AW-1:0] dma_addr,
    input  logic [31:0]   dma_wdata,
    input  logic [3:0]    dma_be,
    output logic          dma_ready,
    output logic          dma_rvalid,
    output logic [31:0]   dma_rdata
);

    localparam int IDXW = AW - 4;

    logic [NBANK-1:0]             cpu_need, cpu_lane, bank_idle;
    logic [NBANK-1:0]             cpu_acc, dma_acc, bk_acc, bk_we;
    logic [NBANK-1:0][IDXW-1:0]   bk_idx;
    logic [NBANK-1:0][WORD_W-1:0] bk_wdata, bk_rdata;
    logic [NBANK-1:0][BE_W-1:0]   bk_be;
    rsp_tag_t [NBANK-1:0]         bk_tag, bk_rtag;
    logic [NBANK-1:0]             bk_rvalid;
    logic [1:0]                   dma_bank;
    logic                         cpu_go, dma_go;
    logic                         addr_unused;

    assign addr_unused = ^{cpu_addr[1:0], dma_addr[1:0]};

    tcm_cpu_decode u_dec (
        .req  (cpu_req),
        .wide (cpu_wide),
        .addr (cpu_addr[3:2]),
        .need (cpu_need),
        .lane (cpu_lane)
    );

    // Processor goes when every bank it needs is idle; DMA yields any bank the processor wants.
    assign dma_bank  = dma_addr[3:2];
    assign cpu_go    = cpu_req & ((cpu_need & ~bank_idle) == '0);
    assign dma_go    = dma_req & bank_idle[dma_bank] & ~cpu_need[dma_bank];
    assign cpu_ready = cpu_go;
    assign dma_ready = dma_go;

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        assign cpu_acc[b]  = cpu_go & cpu_need[b];
        assign dma_acc[b]  = dma_go & (dma_bank == 2'(b));
        assign bk_acc[b]   = cpu_acc[b] | dma_acc[b];
        assign bk_we[b]    = cpu_acc[b] ? cpu_we : dma_we;
        assign bk_idx[b]   = cpu_acc[b] ? cpu_addr[AW-1:4] : dma_addr[AW-1:4];
        assign bk_wdata[b] = !cpu_acc[b] ? dma_wdata :
                             (cpu_lane[b] ? cpu_wdata[63:32] : cpu_wdata[31:0]);
        assign bk_be[b]    = !cpu_acc[b] ? dma_be :
                             (cpu_lane[b] ? cpu_be[7:4] : cpu_be[3:0]);
        assign bk_tag[b]   = cpu_acc[b] ? '{src: SRC_CPU, rd: ~cpu_we, lane: cpu_lane[b]}
                                        : '{src: SRC_DMA, rd: ~dma_we, lane: 1'b0};

        tcm_bank #(
            .IDXW        (IDXW),
            .WAIT_STATES (WAIT_STATES)
        ) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .acc       (bk_acc[b]),
            .we        (bk_we[b]),
            .idx       (bk_idx[b]),
            .wdata     (bk_wdata[b]),
            .be        (bk_be[b]),
            .tag_in    (bk_tag[b]),
            .idle      (bank_idle[b]),
            .rsp_valid (bk_rvalid[b]),
            .rsp_tag   (bk_rtag[b]),
            .rsp_data  (bk_rdata[b])
        );
    end

    tcm_rd_steer u_steer (
        .rsp_valid  (bk_rvalid),
        .rsp_tag    (bk_rtag),
        .rsp_data   (bk_rdata),
        .cpu_rvalid (cpu_rvalid),
        .cpu_rdata  (cpu_rdata),
        .dma_rvalid (dma_rvalid),
        .dma_rdata  (dma_rdata)
    );

endmodule

// File: rtl/tcm_arb_chk.sv
module tcm_arb_chk #(
    parameter int WAIT_STATES = 1
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cpu_req,
    input logic       cpu_we,
    input logic       cpu_wide,
    input logic [3:2] cpu_a,
    input logic       cpu_ready,
    input logic       cpu_rvalid,
    input logic       dma_req,
    input logic       dma_we,
    input logic [3:2] dma_a,
    input logic       dma_ready,
    input logic       dma_rvalid
);

    localparam int LAT = WAIT_STATES + 1;

    logic [LAT-1:0] cpu_pipe, dma_pipe;
    logic           same_bank;

    assign same_bank = cpu_wide ? (cpu_a[3] == dma_a[3]) : (cpu_a == dma_a);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cpu_pipe <= '0;
            dma_pipe <= '0;
        end else begin
            cpu_pipe <= (cpu_pipe << 1) | LAT'(cpu_req & cpu_ready & ~cpu_we);
            dma_pipe <= (dma_pipe << 1) | LAT'(dma_req & dma_ready & ~dma_we);
        end
    end

    AST_CPU_READY_REQ: assert property (@(posedge clk) disable iff (!rst_n) !cpu_req |-> !cpu_ready); // R1
    AST_DMA_READY_REQ: assert property (@(posedge clk) disable iff (!rst_n) !dma_req |-> !dma_ready); // R1
    AST_WIDE_ALIGNED:  assert property (@(posedge clk) disable iff (!rst_n) (cpu_req && cpu_wide) |-> !cpu_a[2]); // R3
    AST_CPU_WINS:      assert property (@(posedge clk) disable iff (!rst_n) (cpu_req && dma_req && same_bank) |-> !dma_ready); // R5
    AST_DMA_HELD:      assert property (@(posedge clk) disable iff (!rst_n) (dma_req && !dma_ready) |=> (dma_req && $stable(dma_a))); // R6
    AST_CPU_RD_LAT:    assert property (@(posedge clk) disable iff (!rst_n) cpu_pipe[LAT-1] |-> cpu_rvalid); // R8
    AST_DMA_RD_LAT:    assert property (@(posedge clk) disable iff (!rst_n) dma_pipe[LAT-1] |-> dma_rvalid); // R8
    AST_CPU_NO_STRAY:  assert property (@(posedge clk) disable iff (!rst_n) cpu_rvalid |-> cpu_pipe[LAT-1]); // R10
    AST_DMA_NO_STRAY:  assert property (@(posedge clk) disable iff (!rst_n) dma_rvalid |-> dma_pipe[LAT-1]); // R10
    AST_BANK_BUSY:     assert property (@(posedge clk) disable iff (!rst_n)
                           ((WAIT_STATES > 0) && dma_req && dma_ready) |=> !(dma_ready && dma_a == $past(dma_a))); // R9

endmodule

bind tcm_bank_arbiter tcm_arb_chk #(
    .WAIT_STATES (WAIT_STATES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_req    (cpu_req),
    .cpu_we     (cpu_we),
    .cpu_wide   (cpu_wide),
    .cpu_a      (cpu_addr[3:2]),
    .cpu_ready  (cpu_ready),
    .cpu_rvalid (cpu_rvalid),
    .dma_req    (dma_req),
    .dma_we     (dma_we),
    .dma_a      (dma_addr[3:2]),
    .dma_ready  (dma_ready),
    .dma_rvalid (dma_rvalid)
);

// File: tb/tb_tcm_bank_arbiter.sv
module tb_tcm_bank_arbiter;

    localparam int CLK_PERIOD = 10;
    localparam int AW         = 12;
    localparam int WS         = 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic          cpu_req, cpu_we, cpu_wide, cpu_ready, cpu_rvalid;
    logic [AW-1:0] cpu_addr;
    logic [63:0]   cpu_wdata, cpu_rdata;
    logic [7:0]    cpu_be;
    logic          dma_req, dma_we, dma_ready, dma_rvalid;
    logic [AW-1:0] dma_addr;
    logic [31:0]   dma_wdata, dma_rdata;
    logic [3:0]    dma_be;

    // Staged inputs, applied at the next falling edge.
    logic          n_cpu_req, n_cpu_we, n_cpu_wide;
    logic [AW-1:0] n_cpu_addr;
    logic [63:0]   n_cpu_wdata;
    logic [7:0]    n_cpu_be;
    logic          n_dma_req, n_dma_we;
    logic [AW-1:0] n_dma_addr;
    logic [31:0]   n_dma_wdata;
    logic [3:0]    n_dma_be;

    tcm_bank_arbiter #(.AW(AW), .WAIT_STATES(WS)) dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_wide(cpu_wide), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_be(cpu_be), .cpu_ready(cpu_ready),
        .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata),
        .dma_req(dma_req), .dma_we(dma_we), .dma_addr(dma_addr), .dma_wdata(dma_wdata),
        .dma_be(dma_be), .dma_ready(dma_ready), .dma_rvalid(dma_rvalid), .dma_rdata(dma_rdata)
    );

    // Behavioural reference state.
    logic [7:0]  mem_m [0:(1<<AW)-1];
    int          busy [4];
    bit          ecv [int];
    logic [63:0] ecd [int];
    bit          edv [int];
    logic [31:0] edd [int];
    int          cyc;
    int          checks;
    int          fails;
    string       ph;
    bit          cpu_took, dma_took;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s [%s] actual %h expected %h", tag, ph, act, exp);
        end
    endtask

    task automatic step();
        bit          ev;
        logic [63:0] ed;
        bit [3:0]    need;
        bit          cok, dok;
        int          d, base, n;
        logic [63:0] v;
        @(negedge clk);
        ev = ecv.exists(cyc);
        ed = ev ? ecd[cyc] : 64'h0;
        chk(cpu_rvalid === ev, "R8/R10 cpu_rvalid", 64'(cpu_rvalid), 64'(ev));
        if (ev) chk(cpu_rdata === ed, "R8 cpu_rdata", cpu_rdata, ed);
        ev = edv.exists(cyc);
        ed = ev ? 64'(edd[cyc]) : 64'h0;
        chk(dma_rvalid === ev, "R8/R10 dma_rvalid", 64'(dma_rvalid), 64'(ev));
        if (ev) chk(dma_rdata === ed[31:0], "R8 dma_rdata", 64'(dma_rdata), ed);
        cpu_req = n_cpu_req; cpu_we = n_cpu_we; cpu_wide = n_cpu_wide;
        cpu_addr = n_cpu_addr; cpu_wdata = n_cpu_wdata; cpu_be = n_cpu_be;
        dma_req = n_dma_req; dma_we = n_dma_we; dma_addr = n_dma_addr;
        dma_wdata = n_dma_wdata; dma_be = n_dma_be;
        #1;
        for (int b = 0; b < 4; b++)
            need[b] = cpu_req && (cpu_wide ? ((b / 2) == int'(cpu_addr[3])) : (b == int'(cpu_addr[3:2])));
        cok = cpu_req;
        for (int b = 0; b < 4; b++) if (need[b] && busy[b] != 0) cok = 1'b0;
        d   = int'(dma_addr[3:2]);
        dok = dma_req && busy[d] == 0 && !need[d];
        chk(cpu_ready === cok, "R9 cpu_ready", 64'(cpu_ready), 64'(cok));
        chk(dma_ready === dok, "R5 dma_ready", 64'(dma_ready), 64'(dok));
        cpu_took = cok;
        dma_took = dok;
        for (int b = 0; b < 4; b++) if (busy[b] > 0) busy[b]--;
        if (cok) begin
            n    = cpu_wide ? 8 : 4;
            base = cpu_wide ? int'({cpu_addr[AW-1:3], 3'b000}) : int'({cpu_addr[AW-1:2], 2'b00});
            if (cpu_we) begin
                for (int i = 0; i < n; i++) if (cpu_be[i]) mem_m[base+i] = cpu_wdata[8*i +: 8];
            end else begin
                v = '0;
                for (int i = 0; i < n; i++) v[8*i +: 8] = mem_m[base+i];
                ecv[cyc+1+WS] = 1'b1;
                ecd[cyc+1+WS] = v;
            end
            for (int b = 0; b < 4; b++) if (need[b]) busy[b] = WS;
        end
        if (dok) begin
            base = int'({dma_addr[AW-1:2], 2'b00});
            if (dma_we) begin
                for (int i = 0; i < 4; i++) if (dma_be[i]) mem_m[base+i] = dma_wdata[8*i +: 8];
            end else begin
                v = '0;
                for (int i = 0; i < 4; i++) v[8*i +: 8] = mem_m[base+i];
                edv[cyc+1+WS] = 1'b1;
                edd[cyc+1+WS] = v[31:0];
            end
            busy[d] = WS;
        end
        cyc++;
    endtask

    task automatic cpu_set(input bit req, input bit we, input bit wide, input int addr,
                           input logic [63:0] wd, input logic [7:0] be);
        n_cpu_req = req; n_cpu_we = we; n_cpu_wide = wide;
        n_cpu_addr = AW'(addr); n_cpu_wdata = wd; n_cpu_be = be;
    endtask

    task automatic dma_set(input bit req, input bit we, input int addr,
                           input logic [31:0] wd, input logic [3:0] be);
        n_dma_req = req; n_dma_we = we; n_dma_addr = AW'(addr);
        n_dma_wdata = wd; n_dma_be = be;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) step();
    endtask

    task automatic cpu_xfer(input bit we, input bit wide, input int addr,
                            input logic [63:0] wd, input logic [7:0] be);
        cpu_set(1'b1, we, wide, addr, wd, be);
        for (int k = 0; k < 20; k++) begin
            step();
            if (cpu_took) break;
        end
        cpu_set(1'b0, 1'b0, 1'b0, 0, 64'h0, 8'h0);
    endtask

    task automatic dma_xfer(input bit we, input int addr, input logic [31:0] wd, input logic [3:0] be);
        dma_set(1'b1, we, addr, wd, be);
        for (int k = 0; k < 20; k++) begin
            step();
            if (dma_took) break;
        end
        dma_set(1'b0, 1'b0, 0, 32'h0, 4'h0);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        fails++;
        $display("FAIL R8 watchdog expired actual %0d expected %0d", cyc, 0);
        summary();
        $finish;
    end

    initial begin
        int  cnt;
        bit  cp, dp, wide;
        int  a;
        checks = 0; fails = 0; cyc = 0; ph = "R1";
        for (int b = 0; b < 4; b++) busy[b] = 0;
        cpu_set(1'b0, 1'b0, 1'b0, 0, 64'h0, 8'h0);
        dma_set(1'b0, 1'b0, 0, 32'h0, 4'h0);
        cpu_req = 0; cpu_we = 0; cpu_wide = 0; cpu_addr = '0; cpu_wdata = '0; cpu_be = '0;
        dma_req = 0; dma_we = 0; dma_addr = '0; dma_wdata = '0; dma_be = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(cpu_rvalid === 1'b0, "R1 cpu_rvalid after reset", 64'(cpu_rvalid), 64'h0);
        chk(dma_rvalid === 1'b0, "R1 dma_rvalid after reset", 64'(dma_rvalid), 64'h0);
        chk(cpu_ready === 1'b0, "R1 cpu_ready without request", 64'(cpu_ready), 64'h0);
        chk(dma_ready === 1'b0, "R1 dma_ready without request", 64'(dma_ready), 64'h0);
        idle(2);

        // Prefill the low 256 bytes with doubleword writes.
        ph = "R3";
        for (int p = 0; p < 256; p += 8)
            cpu_xfer(1'b1, 1'b1, p, 64'hA5A5_0000_5A5A_0000 | {16'h0, 16'(p + 4), 16'h0, 16'(p)}, 8'hFF);
        idle(3);
        cpu_xfer(1'b0, 1'b1, 'h10, 64'h0, 8'h0);
        cpu_xfer(1'b0, 1'b1, 'h18, 64'h0, 8'h0);
        idle(3);

        ph = "R2";
        cpu_xfer(1'b1, 1'b0, 'h24, 64'h0000_0000_A5C3_1234, 8'h0F);
        dma_xfer(1'b0, 'h24, 32'h0, 4'h0);
        dma_xfer(1'b1, 'h38, 32'h7E57_0D0A, 4'hF);
        cpu_xfer(1'b0, 1'b0, 'h38, 64'h0, 8'h0);
        idle(3);

        ph = "R4";
        cpu_set(1'b1, 1'b0, 1'b0, 'h00, 64'h0, 8'h0);
        dma_set(1'b1, 1'b0, 'h28, 32'h0, 4'h0);
        step();
        chk(cpu_ready === 1'b1 && dma_ready === 1'b1, "R4 both granted", 64'({cpu_ready, dma_ready}), 64'h3);
        cpu_set(1'b0, 1'b0, 1'b0, 0, 64'h0, 8'h0);
        dma_set(1'b0, 1'b0, 0, 32'h0, 4'h0);
        idle(3);

        ph = "R5";
        cpu_set(1'b1, 1'b0, 1'b0, 'h04, 64'h0, 8'h0);
        dma_set(1'b1, 1'b0, 'h44, 32'h0, 4'h0);
        step();
        chk(cpu_ready === 1'b1 && dma_ready === 1'b0, "R5 processor wins bank 1", 64'({cpu_ready, dma_ready}), 64'h2);
        ph = "R6";
        cpu_set(1'b1, 1'b0, 1'b0, 'h08, 64'h0, 8'h0);
        cnt = 0;
        for (int k = 0; k < 10; k++) begin
            step();
            cnt++;
            if (cpu_took) cpu_set(1'b0, 1'b0, 1'b0, 0, 64'h0, 8'h0);
            if (dma_took) break;
        end
        chk(cnt == 2, "R6 held DMA granted once bank free", 64'(cnt), 64'd2);
        dma_set(1'b0, 1'b0, 0, 32'h0, 4'h0);
        idle(3);

        ph = "R9";
        cpu_set(1'b1, 1'b0, 1'b0, 'h0C, 64'h0, 8'h0);
        step();
        cpu_set(1'b1, 1'b0, 1'b0, 'h1C, 64'h0, 8'h0);
        step();
        chk(cpu_ready === 1'b0, "R9 bank 3 busy in wait state", 64'(cpu_ready), 64'h0);
        step();
        chk(cpu_ready === 1'b1, "R9 bank 3 free after wait state", 64'(cpu_ready), 64'h1);
        cpu_set(1'b0, 1'b0, 1'b0, 0, 64'h0, 8'h0);
        idle(3);

        ph = "R7";
        cpu_xfer(1'b1, 1'b0, 'h30, 64'h0000_0000_DEAD_BEEF, 8'h0F);
        cpu_xfer(1'b1, 1'b0, 'h30, 64'h0000_0000_1122_3344, 8'h05);
        dma_xfer(1'b0, 'h30, 32'h0, 4'h0);
        idle(3);
        chk(mem_m['h30] == 8'h44 && mem_m['h33] == 8'hDE, "R7 model byte merge", 64'({mem_m['h33], mem_m['h30]}), 64'hDE44);
        cpu_xfer(1'b1, 1'b1, 'h40, 64'h0123_4567_89AB_CDEF, 8'hF0);
        cpu_xfer(1'b0, 1'b1, 'h40, 64'h0, 8'h0);
        dma_xfer(1'b1, 'h48, 32'hCAFE_F00D, 4'hA);
        dma_xfer(1'b0, 'h48, 32'h0, 4'h0);
        idle(3);

        ph = "R10";
        cpu_xfer(1'b1, 1'b1, 'h50, 64'h1111_2222_3333_4444, 8'hFF);
        dma_xfer(1'b1, 'h60, 32'h5555_6666, 4'hF);
        idle(4);

        ph = "R8";
        cp = 1'b0; dp = 1'b0;
        for (int k = 0; k < 1500; k++) begin
            if (!cp && $urandom_range(0, 1) == 1) begin
                wide = ($urandom_range(0, 2) == 0);
                a = $urandom_range(0, 255);
                a = wide ? (a & 'hF8) : (a & 'hFC);
                cpu_set(1'b1, $urandom_range(0, 3) == 0, wide, a, {$urandom, $urandom}, 8'($urandom));
                cp = 1'b1;
            end
            if (!dp && $urandom_range(0, 1) == 1) begin
                a = $urandom_range(0, 255) & 'hFC;
                dma_set(1'b1, $urandom_range(0, 3) == 0, a, $urandom, 4'($urandom));
                dp = 1'b1;
            end
            step();
            if (cpu_took) begin cp = 1'b0; cpu_set(1'b0, 1'b0, 1'b0, 0, 64'h0, 8'h0); end
            if (dma_took) begin dp = 1'b0; dma_set(1'b0, 1'b0, 0, 32'h0, 4'h0); end
        end
        cpu_set(1'b0, 1'b0, 1'b0, 0, 64'h0, 8'h0);
        dma_set(1'b0, 1'b0, 0, 32'h0, 4'h0);
        idle(4);

        summary();
        $finish;
    end

endmodule